// File: doc/BRIEF.md
# Dual-Clock Preloadable Countdown Timer

This block is a down-counting timer whose counting engine runs on a slow, free-running clock (nominally 32768 Hz), while software reaches it through a small word-addressed register bus on a fast system clock. Software writes a reload value, then sets enable and start. The rising edge of start, once it has crossed into the slow domain, copies the reload value into the counter. The counter then steps down once per slow clock. When it hits zero it raises a sticky pending flag, which drives a level interrupt, and reloads itself if start is still set. Writing zero to the control word stops the timer and removes the pending flag.

Control bits and reload updates cross into the slow domain through two-flop synchronizers. The live count returns to the bus domain through a toggle request/acknowledge handshake, so a read never returns a half-updated word. A debug-halt input can freeze the count when the halt-enable bit allows it.

The slow domain is one state machine with four states:
- `S_OFF`: block disabled.
- `S_ARMED`: enabled, waiting for a start edge.
- `S_RUN`: counting.
- `S_RELOAD`: just expired.

Its transitions are:
- enable-on: `S_OFF` to `S_ARMED`.
- start-edge: `S_ARMED` to `S_RUN`.
- expire: `S_RUN` to `S_RELOAD`.
- start-drop: `S_RUN` to `S_ARMED`.
- reload: `S_RELOAD` to `S_RUN`.
- idle: `S_RELOAD` to `S_ARMED`.
- disable: any state to `S_OFF`.

Top module: `slow_countdown_timer`

## Requirements
- R1: After reset the control word (address 0), reload word (address 1), count word (address 2) and `irq` all read zero.
- R2: Reload and count are 28 bits wide. Bits 31:28 always read zero, so writing 0xFFFFFFFF to the reload word reads back 0x0FFFFFFF, and that maximum can be loaded and counted from.
- R3: The count word is read-only. A bus write to address 2 leaves its value unchanged.
- R4: The control word has enable at bit 0, start at bit 1 and halt-enable at bit 2, all readable at once after a write, plus a read-only pending bit at bit 3. Right after start is set, while the load is still in flight, the count reads zero and the start bit reads one.
- R5: From a loaded value P the count steps down once per slow clock. On the step from 1 to 0, or when P is zero, the pending bit and `irq` set and stay set. `irq` rises between P+1 and P+6 slow periods after the start write.
- R6: After an expiry with enable and start still set, the count is reloaded from the reload word on the next slow clock and counting continues.
- R7: A control write with enable at zero clears the pending bit and `irq` within a few slow periods.
- R8: A reload write while counting does not change the running count. The new value is used at the next reload.
- R9: While halt-enable is set and `dbg_halt` is high, the count holds. With halt-enable clear, `dbg_halt` has no effect.
- R10: Clearing enable forces the count to zero and forgets the previous start level, so the next enable with start set loads afresh.
- R11: Clearing start while counting holds the count. Only a new 0-to-1 start edge reloads it.
- R12: Successive bus reads of the count while it runs never increase and never return a torn value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Active-low async reset, bus domain |
| slow_clk | input | 1 | Counting clock (32768 Hz nominal) |
| slow_rst_n | input | 1 | Active-low async reset, slow domain |
| reg_addr | input | 2 | Word address: 0 control, 1 reload, 2 count |
| reg_wr | input | 1 | Write strobe, one bus cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| dbg_halt | input | 1 | Debug-halt request, asynchronous |
| irq | output | 1 | Level interrupt, copy of the pending bit |

## Verification
Register writes and reload readback take effect on the next bus edge. Slow-domain effects such as the load, the freeze and the clear land two to three slow edges after a write, and the bus view of the count trails the real count by up to about four slow periods through the handshake. For that reason the bench either waits a fixed number of slow periods well past that latency before reading, or compares against windows: the expiry window in R5, upper and lower bounds on the count, and equality of two reads taken while the count is frozen or held. `irq` is sampled on every bus cycle while the bench waits for it, so its arrival is measured directly in bus cycles and compared with the P+1 to P+6 slow-period window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        S_OFF    = 2'd0,
        S_ARMED  = 2'd1,
        S_RUN    = 2'd2,
        S_RELOAD = 2'd3
    } tmr_state_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;

    localparam int CTL_EN    = 0;
    localparam int CTL_START = 1;
    localparam int CTL_HALT  = 2;
    localparam int CTL_PEND  = 3;
    localparam int CTL_W     = 3;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_cnt_xfer.sv
module tmr_cnt_xfer #(
    parameter int W      = 28,
    parameter int STAGES = 2
) (
    input  logic         s_clk,
    input  logic         s_rst_n,
    input  logic [W-1:0] s_val,
    input  logic         b_clk,
    input  logic         b_rst_n,
    output logic [W-1:0] b_val
);
    logic         req_t, ack_t, ack_s, req_b;
    logic [W-1:0] snap;

    // slow side: publish a new snapshot only once the previous one is acknowledged
    always_ff @(posedge s_clk or negedge s_rst_n) begin
        if (!s_rst_n) begin
            snap  <= '0;
            req_t <= 1'b0;
        end else if (req_t == ack_s) begin
            snap  <= s_val;
            req_t <= ~req_t;
        end
    end

    tmr_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
        .clk(s_clk), .rst_n(s_rst_n), .d(ack_t), .q(ack_s)
    );
    tmr_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk(b_clk), .rst_n(b_rst_n), .d(req_t), .q(req_b)
    );

    // bus side: snapshot is stable whenever the request toggle differs from ack
    always_ff @(posedge b_clk or negedge b_rst_n) begin
        if (!b_rst_n) begin
            b_val <= '0;
            ack_t <= 1'b0;
        end else if (req_b != ack_t) begin
            b_val <= snap;
            ack_t <= req_b;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic             start_s,
    input  logic             halt_en_s,
    input  logic             dbg_halt_s,
    input  logic             rl_upd,
    input  logic [CNT_W-1:0] rl_bus,
    output logic [CNT_W-1:0] count,
    output logic             pending,
    output tmr_state_t       state
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_t       state_nx;
    logic [CNT_W-1:0] rl_shadow, load_val;
    logic             start_q, start_edge, frozen, step_ok, at_end;

    assign load_val   = rl_upd ? rl_bus : rl_shadow;
    assign start_edge = start_s & ~start_q;
    assign frozen     = halt_en_s & dbg_halt_s;
    assign step_ok    = start_s & ~frozen;
    assign at_end     = (count <= ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:    if (en_s) state_nx = S_ARMED;
            S_ARMED:  if (start_edge) state_nx = S_RUN;
            S_RUN: begin
                if (!start_s)               state_nx = S_ARMED;
                else if (!frozen && at_end) state_nx = S_RELOAD;
            end
            S_RELOAD: state_nx = start_s ? S_RUN : S_ARMED;
            default:  state_nx = S_OFF;
        endcase
        if (!en_s) state_nx = S_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            pending   <= 1'b0;
            rl_shadow <= '0;
            start_q   <= 1'b0;
        end else begin
            if (rl_upd) rl_shadow <= rl_bus;
            start_q <= (state == S_OFF || !en_s) ? 1'b0 : start_s;
            unique case (state)
                S_OFF: begin
                    count   <= '0;
                    pending <= 1'b0;
                end
                S_ARMED:  if (start_edge) count <= load_val;
                S_RUN: begin
                    if (step_ok) begin
                        if (at_end) begin
                            count   <= '0;
                            pending <= 1'b1;
                        end else begin
                            count <= count - ONE;
                        end
                    end
                end
                S_RELOAD: if (start_s) count <= load_val;
                default:  count <= '0;
            endcase
            if (!en_s) begin
                count   <= '0;
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/slow_countdown_timer.sv
module slow_countdown_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 28,
    parameter int STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dbg_halt,
    output logic              irq
);
    logic [CTL_W-1:0] ctrl_q;
    logic [CNT_W-1:0] reload_q, count_s, count_b;
    logic             rl_tgl, rl_tgl_s, rl_tgl_q, pend_s;
    logic [CTL_W:0]   to_slow, from_bus;
    tmr_state_t       st;

    // bus-side register file
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            rl_tgl   <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL:   ctrl_q <= reg_wdata[CTL_W-1:0];
                ADDR_RELOAD: begin
                    reload_q <= reg_wdata[CNT_W-1:0];
                    rl_tgl   <= ~rl_tgl;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTL_W-1:0] = ctrl_q;
                reg_rdata[CTL_PEND]  = irq;
            end
            ADDR_RELOAD: reg_rdata[CNT_W-1:0] = reload_q;
            ADDR_COUNT:  reg_rdata[CNT_W-1:0] = count_b;
            default:     reg_rdata = '0;
        endcase
    end

    // bus -> slow: control levels, debug halt and the reload toggle
    assign to_slow = {dbg_halt, ctrl_q};
    tmr_sync #(.W(CTL_W+1), .STAGES(STAGES)) u_ctl_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(to_slow), .q(from_bus)
    );
    tmr_sync #(.W(1), .STAGES(STAGES)) u_rl_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(rl_tgl), .q(rl_tgl_s)
    );
    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) rl_tgl_q <= 1'b0;
        else             rl_tgl_q <= rl_tgl_s;
    end

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (slow_clk),
        .rst_n      (slow_rst_n),
        .en_s       (from_bus[CTL_EN]),
        .start_s    (from_bus[CTL_START]),
        .halt_en_s  (from_bus[CTL_HALT]),
        .dbg_halt_s (from_bus[CTL_W]),
        .rl_upd     (rl_tgl_s ^ rl_tgl_q),
        .rl_bus     (reload_q),
        .count      (count_s),
        .pending    (pend_s),
        .state      (st)
    );

    // slow -> bus: pending level and coherent count
    tmr_sync #(.W(1), .STAGES(STAGES)) u_irq_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(pend_s), .q(irq)
    );
    tmr_cnt_xfer #(.W(CNT_W), .STAGES(STAGES)) u_xfer (
        .s_clk(slow_clk), .s_rst_n(slow_rst_n), .s_val(count_s),
        .b_clk(bus_clk),  .b_rst_n(bus_rst_n),  .b_val(count_b)
    );
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_s,
    input logic             start_s,
    input logic             halt_en_s,
    input logic             dbg_halt_s,
    input logic [CNT_W-1:0] count,
    input logic             pending,
    input tmr_state_t       state
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && en_s && start_s && !(halt_en_s && dbg_halt_s) && count > ONE)
        |=> count == $past(count) - ONE);

    assert_expiry_pends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && en_s && start_s && !(halt_en_s && dbg_halt_s) && count == ONE)
        |=> pending);

    assert_pending_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && en_s) |=> pending);

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (!pending && count == '0));

    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && en_s && halt_en_s && dbg_halt_s) |=> $stable(count));

    assert_start_low_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && en_s && !start_s) |=> $stable(count));
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W)) u_core_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_s       (en_s),
    .start_s    (start_s),
    .halt_en_s  (halt_en_s),
    .dbg_halt_s (dbg_halt_s),
    .count      (count),
    .pending    (pending),
    .state      (state)
);

// File: tb/slow_countdown_timer_tb.sv
module slow_countdown_timer_tb;
    localparam int SLOW_DIV = 10;

    logic        bus_clk = 1'b0, slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq;
    int          checks = 0, errors = 0;

    slow_countdown_timer u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dbg_halt(dbg_halt), .irq(irq)
    );

    always #2 bus_clk = ~bus_clk;
    initial begin
        #7;
        forever #20 slow_clk = ~slow_clk;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge bus_clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_slow(input int n);
        repeat (n) @(posedge slow_clk);
        @(negedge bus_clk);
    endtask

    task automatic wait_irq(input int limit, output int n);
        n = 0;
        while (!irq && n < limit) begin
            @(negedge bus_clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk(v == 0, "R1 ctrl after reset", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 reload after reset", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 count after reset", v, 0);
        chk(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
    endtask

    task automatic t_widths();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk(v == 32'h0FFF_FFFF, "R2 reload upper bits", v, 32'h0FFF_FFFF);
        wr(2'd2, 32'h0000_0055);
        wait_slow(6);
        rd(2'd2, v); chk(v == 0, "R3 count write ignored", v, 0);
    endtask

    task automatic t_expire();
        logic [31:0] v;
        int n;
        wr(2'd1, 32'd20);
        wr(2'd0, 32'h3);
        rd(2'd0, v); chk(v == 32'h3, "R4 start bit reads one", v, 32'h3);
        rd(2'd2, v); chk(v == 0, "R4 count zero during load", v, 0);
        wait_irq(60 * SLOW_DIV, n);
        chk(n >= 21 * SLOW_DIV && n <= 26 * SLOW_DIV, "R5 expiry time window (bus cycles)", n, 21 * SLOW_DIV);
        wait_slow(6);
        rd(2'd2, v); chk(v != 0 && v <= 20, "R6 auto reload after expiry", v, 20);
        rd(2'd0, v); chk(v[3] == 1'b1 && irq, "R5 pending sticky", v, 32'hB);
        wr(2'd0, 32'h0);
        wait_slow(8);
        chk(irq == 1'b0, "R7 irq cleared by disable", {31'd0, irq}, 0);
        rd(2'd0, v); chk(v == 0, "R7 pending bit cleared", v, 0);
        rd(2'd2, v); chk(v == 0, "R10 count zero when disabled", v, 0);
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h3);
        wait_irq(10 * SLOW_DIV, n);
        chk(irq == 1'b1, "R5 zero reload expires at once", {31'd0, irq}, 1);
        wr(2'd0, 32'h0);
        wait_slow(8);
    endtask

    task automatic t_defer();
        logic [31:0] v;
        int n;
        wr(2'd1, 32'd300);
        wr(2'd0, 32'h3);
        wait_slow(10);
        wr(2'd1, 32'd8);
        wait_slow(10);
        rd(2'd2, v); chk(v >= 250 && v <= 300, "R8 running count unaffected", v, 300);
        wait_irq(320 * SLOW_DIV, n);
        chk(irq == 1'b1, "R5 long period expires", {31'd0, irq}, 1);
        wait_slow(6);
        rd(2'd2, v); chk(v >= 1 && v <= 8, "R8 new reload used next period", v, 8);
        wr(2'd0, 32'h0);
        wait_slow(8);
    endtask

    task automatic t_halt();
        logic [31:0] a, b, c, d, e;
        wr(2'd1, 32'd1000);
        wr(2'd0, 32'h7);
        wait_slow(10);
        dbg_halt = 1'b1;
        wait_slow(8);
        rd(2'd2, a);
        wait_slow(20);
        rd(2'd2, b);
        chk(a == b && a != 0, "R9 count frozen while halted", b, a);
        dbg_halt = 1'b0;
        wait_slow(10);
        rd(2'd2, c); chk(c < b, "R9 count resumes after halt", c, b);
        wr(2'd0, 32'h3);
        dbg_halt = 1'b1;
        wait_slow(6);
        rd(2'd2, d);
        wait_slow(10);
        rd(2'd2, e); chk(e < d, "R9 halt ignored without halt enable", e, d);
        dbg_halt = 1'b0;
        wr(2'd0, 32'h0);
        wait_slow(8);
    endtask

    task automatic t_restart();
        logic [31:0] f, g, h, k;
        wr(2'd1, 32'd1000);
        wr(2'd0, 32'h3);
        wait_slow(30);
        wr(2'd0, 32'h1);
        wait_slow(8);
        rd(2'd2, f);
        wait_slow(20);
        rd(2'd2, g);
        chk(f == g && g != 0, "R11 count held with start low", g, f);
        wr(2'd0, 32'h3);
        wait_slow(10);
        rd(2'd2, h); chk(h > g && h <= 1000, "R11 new start edge reloads", h, 1000);
        wr(2'd0, 32'h0);
        wait_slow(8);
        rd(2'd2, k); chk(k == 0, "R10 disable zeroes count", k, 0);
        wr(2'd0, 32'h3);
        wait_slow(10);
        rd(2'd2, k); chk(k > 990 && k <= 1000, "R10 fresh edge after disable", k, 1000);
        wr(2'd0, 32'h0);
        wait_slow(8);
    endtask

    task automatic t_coherent();
        logic [31:0] v, prev;
        int bad = 0;
        wr(2'd1, 32'h0FFF_FFFF);
        wr(2'd0, 32'h3);
        wait_slow(12);
        rd(2'd2, prev);
        chk(prev <= 32'h0FFF_FFFF && prev > 32'h0FFF_FF00, "R2 maximum reload counts", prev, 32'h0FFF_FFFF);
        for (int i = 0; i < 400; i++) begin
            rd(2'd2, v);
            if (v > prev || v < 32'h0FFF_FF00) bad++;
            prev = v;
        end
        chk(bad == 0, "R12 reads monotonic and whole", bad, 0);
        wr(2'd0, 32'h0);
        wait_slow(8);
    endtask

    initial begin
        repeat (5) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        slow_rst_n = 1'b1;
        wait_slow(2);
        t_reset();
        t_widths();
        t_expire();
        t_defer();
        t_halt();
        t_restart();
        t_coherent();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule